// File: doc/BRIEF.md
# Voltage-Compensated Printhead Firing Controller

This block fires one column of a 24-wire impact printhead in three back-to-back phases. The host writes the column as three 8-bit groups into holding registers. A start strobe then begins a firing sequence. At that moment the block samples the supply-rail reading from an 8-bit converter. It turns the upper four bits of that reading into a drive-pulse width through a 16-entry table whose widths fall as the reading rises. A higher rail voltage therefore gives a shorter pulse, and each dot receives about the same energy.

Each phase energises only its own group of eight wires, for exactly the chosen number of cycles. A fixed quiet gap of four cycles follows each phase. The `busy` output covers the whole sequence, and `done` marks its end with a one-cycle pulse. The converter, the power switches and the head mechanics are outside this block.

Top module: `hdfire_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `head_drv` is all zero and both `busy` and `done` are low.
- R2: A write with `wr_en` high and `wr_sel` = g (0, 1 or 2) loads `wr_data` into group g at the next clock edge. Bit b of `wr_data` maps to `head_drv` bit 8*g+b. A write with `wr_sel` = 3 changes no stored data.
- R3: The three groups fire in the order 0, 1, 2. During a phase, no `head_drv` bit outside the active group is set.
- R4: During the pulse of phase g, each `head_drv` bit of group g equals its stored data bit. Outside a pulse, all bits are zero.
- R5: The pulse of every phase lasts W = 64 - 4*k clock cycles, where k = `adc_val[7:4]`.
- R6: A larger value of `adc_val[7:4]` gives a strictly shorter pulse.
- R7: `adc_val` is sampled only at the clock edge that accepts the start. Later changes to it do not alter any pulse of that column.
- R8: After each phase comes a gap of exactly 4 cycles in which `head_drv` is zero.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the accepting edge for 3*(W+4) cycles. A `start` that arrives while `busy` is high has no effect.
- R10: `done` is high for exactly one cycle: the first cycle after the final gap, when `busy` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the group registers |
| wr_sel | input | 2 | Group select for a write (3 = no target) |
| wr_data | input | 8 | Dot data for the selected group |
| start | input | 1 | Begin firing the stored column |
| adc_val | input | 8 | Supply-rail reading |
| head_drv | output | 24 | Head-drive lines, bit 0 = wire 1 |
| busy | output | 1 | Column firing in progress |
| done | output | 1 | One-cycle end-of-column pulse |

## Verification
Inputs are driven and outputs sampled on the falling edge. Take the edge that accepts `start` as cycle 0, and call the sample right after it k = 0. Then group g is expected to be driving at the samples k in [g*(W+4), g*(W+4)+W-1]. `busy` is expected high for k < 3*(W+4), and `done` is expected high only at k = 3*(W+4). The bench compares `head_drv`, `busy` and `done` at every sample from k = 0 to one cycle past `done`. W is computed from the reading held at the start. The same per-cycle schedule is used to check a reading that changes mid-column and a second start that arrives mid-column.

// File: rtl/hdfire_pkg.sv
package hdfire_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FIRE = 2'd1,
      ST_GAP  = 2'd2
   } fire_st_e;

   // Width table entry i: linearly falling from the widest pulse
   function automatic int unsigned width_entry(input int unsigned top,
                                               input int unsigned step,
                                               input int unsigned i);
      return top - i * step;
   endfunction

endpackage

// File: rtl/hdfire_latch.sv
module hdfire_latch #(
   parameter int GRP      = 8,
   parameter int PORTIONS = 3,
   parameter int SEL_W    = 2,
   localparam int WIRES   = GRP * PORTIONS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [GRP-1:0]   wr_data,
   output logic [WIRES-1:0] held
);

   initial assert ((1 << SEL_W) >= PORTIONS)
      else $error("hdfire_latch: SEL_W too narrow for PORTIONS");

   for (genvar g = 0; g < PORTIONS; g++) begin : g_bank
      logic [GRP-1:0] bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q <= '0;
         else if (wr_en && wr_sel == SEL_W'(g))
            bank_q <= wr_data;
      end
      assign held[g*GRP +: GRP] = bank_q;
   end

endmodule

// File: rtl/hdfire_width.sv
module hdfire_width
   import hdfire_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int W_MAX  = 64,
   parameter int W_STEP = 4,
   parameter int CNT_W  = 7,
   localparam int ENT   = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] width
);

   initial begin
      assert (W_STEP >= 1)
         else $error("hdfire_width: W_STEP must be positive");
      assert (W_MAX - (ENT - 1) * W_STEP >= 1)
         else $error("hdfire_width: smallest entry must be at least 1");
      assert (W_MAX < (1 << CNT_W))
         else $error("hdfire_width: CNT_W too narrow for W_MAX");
   end

   logic [CNT_W-1:0] tbl_q [ENT];

   // Table is loaded while reset is held and then kept
   for (genvar i = 0; i < ENT; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl_q[i] <= CNT_W'(width_entry(W_MAX, W_STEP, i));
      end
   end

   assign width = tbl_q[idx];

endmodule

// File: rtl/hdfire_seq.sv
module hdfire_seq
   import hdfire_pkg::*;
#(
   parameter int PORTIONS = 3,
   parameter int GAP_CYC  = 4,
   parameter int CNT_W    = 7,
   parameter int PH_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] width_in,
   output logic             fire,
   output logic [PH_W-1:0]  phase,
   output logic             busy,
   output logic             done
);

   localparam logic [PH_W-1:0]  LAST_PH = PH_W'(PORTIONS - 1);
   localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_CYC - 1);

   initial begin
      assert (GAP_CYC >= 1 && GAP_CYC < (1 << CNT_W))
         else $error("hdfire_seq: GAP_CYC out of range");
      assert ((1 << PH_W) >= PORTIONS)
         else $error("hdfire_seq: PH_W too narrow");
   end

   fire_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pw_q;
   logic [PH_W-1:0]  ph_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         pw_q   <= '0;
         ph_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  pw_q  <= width_in;
                  cnt_q <= '0;
                  ph_q  <= '0;
                  st_q  <= ST_FIRE;
               end
            end
            ST_FIRE: begin
               if (cnt_q == pw_q - CNT_W'(1)) begin
                  cnt_q <= '0;
                  st_q  <= ST_GAP;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_GAP: begin
               if (cnt_q == GAP_END) begin
                  cnt_q <= '0;
                  if (ph_q == LAST_PH) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     ph_q <= ph_q + PH_W'(1);
                     st_q <= ST_FIRE;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign fire  = (st_q == ST_FIRE);
   assign phase = ph_q;
   assign busy  = (st_q != ST_IDLE);
   assign done  = done_q;

   // R7: one captured width for the whole column
   p_width_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pw_q));

   // R10: end pulse lasts a single cycle
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: end pulse coincides with the idle state
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3: phases advance in order and never pass the last one
   p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(phase)) |->
         (phase == $past(phase) + PH_W'(1)));

endmodule

// File: rtl/hdfire_ctrl.sv
module hdfire_ctrl #(
   parameter int WIRES    = 24,
   parameter int PORTIONS = 3,
   parameter int ADC_W    = 8,
   parameter int IDX_W    = 4,
   parameter int W_MAX    = 64,
   parameter int W_STEP   = 4,
   parameter int GAP_CYC  = 4,
   localparam int GRP     = WIRES / PORTIONS,
   localparam int SEL_W   = (PORTIONS > 1) ? $clog2(PORTIONS + 1) : 1,
   localparam int PH_W    = (PORTIONS > 1) ? $clog2(PORTIONS) : 1,
   localparam int CNT_MAX = (W_MAX > GAP_CYC) ? W_MAX : GAP_CYC,
   localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [GRP-1:0]   wr_data,
   input  logic             start,
   input  logic [ADC_W-1:0] adc_val,
   output logic [WIRES-1:0] head_drv,
   output logic             busy,
   output logic             done
);

   initial begin
      assert (GRP * PORTIONS == WIRES)
         else $error("hdfire_ctrl: WIRES must split evenly into PORTIONS");
      assert (IDX_W <= ADC_W)
         else $error("hdfire_ctrl: IDX_W wider than ADC_W");
   end

   logic [WIRES-1:0] held;
   logic [CNT_W-1:0] width;
   logic             fire;
   logic [PH_W-1:0]  phase;

   hdfire_latch #(
      .GRP      (GRP),
      .PORTIONS (PORTIONS),
      .SEL_W    (SEL_W)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .held    (held)
   );

   hdfire_width #(
      .IDX_W  (IDX_W),
      .W_MAX  (W_MAX),
      .W_STEP (W_STEP),
      .CNT_W  (CNT_W)
   ) u_width (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (adc_val[ADC_W-1 -: IDX_W]),
      .width (width)
   );

   hdfire_seq #(
      .PORTIONS (PORTIONS),
      .GAP_CYC  (GAP_CYC),
      .CNT_W    (CNT_W),
      .PH_W     (PH_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .width_in (width),
      .fire     (fire),
      .phase    (phase),
      .busy     (busy),
      .done     (done)
   );

   logic [PORTIONS-1:0] grp_on;

   for (genvar g = 0; g < PORTIONS; g++) begin : g_gate
      logic sel;
      assign sel = fire && (phase == PH_W'(g));
      assign head_drv[g*GRP +: GRP] = sel ? held[g*GRP +: GRP] : '0;
      assign grp_on[g] = |head_drv[g*GRP +: GRP];
   end

   // R3: at most one group drives at a time
   p_one_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_on));

   // R4: no drive outside a firing sequence
   p_drive_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|head_drv) |-> busy);

endmodule

// File: tb/tb_hdfire_ctrl.sv
`timescale 1ns/1ps
module tb_hdfire_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        start = 1'b0;
   logic [7:0]  adc_val = '0;
   logic [23:0] head_drv;
   logic        busy;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hdfire_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .start    (start),
      .adc_val  (adc_val),
      .head_drv (head_drv),
      .busy     (busy),
      .done     (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int pw_of(input logic [7:0] a);
      return 64 - 4 * int'(a[7:4]);
   endfunction

   // Fire one column and compare every cycle against the schedule.
   // chg_k: sample index after which adc_val is altered (-1 none)
   // re_k : sample index after which start is pulsed again (-1 none)
   task automatic fire_col(input logic [7:0] adc, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2,
                           input int chg_k, input int re_k, input string req);
      int pw;
      int per;
      int tot;
      logic [23:0] dat;
      pw  = pw_of(adc);
      per = pw + 4;
      tot = 3 * per;
      dat = {d2, d1, d0};
      @(negedge clk);
      adc_val = adc;
      start = 1'b1;
      for (int k = 0; k <= tot + 1; k++) begin
         logic [23:0] e_drv;
         int g;
         int pos;
         @(negedge clk);
         g = k / per;
         pos = k % per;
         e_drv = '0;
         if (g < 3 && pos < pw) e_drv[g*8 +: 8] = dat[g*8 +: 8];
         chk(head_drv === e_drv, req, $sformatf("head_drv k=%0d", k),
             32'(head_drv), 32'(e_drv));
         chk(busy === (k < tot), req, $sformatf("busy k=%0d", k),
             32'(busy), 32'(k < tot));
         chk(done === (k == tot), req, $sformatf("done k=%0d", k),
             32'(done), 32'(k == tot));
         start = (k == re_k);
         if (k == chg_k) adc_val = adc ^ 8'hF0;
      end
      start = 1'b0;
   endtask

   task automatic load_col(input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2);
      wr(2'd0, d0);
      wr(2'd1, d1);
      wr(2'd2, d2);
   endtask

   // R1: reset state
   task automatic t_reset();
      chk(head_drv === '0, "R1", "head_drv in reset", 32'(head_drv), 0);
      chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
      chk(done === 1'b0, "R1", "done in reset", 32'(done), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(head_drv === '0 && !busy && !done, "R1", "after release",
          {head_drv, busy, done}, 0);
   endtask

   // R2 R3 R4 R5 R8 R9 R10: basic columns with several patterns and widths
   task automatic t_basic();
      load_col(8'hA5, 8'h3C, 8'h81);
      fire_col(8'h00, 8'hA5, 8'h3C, 8'h81, -1, -1, "R2 R3 R4 R5 R8 R10");
      load_col(8'hFF, 8'h01, 8'h80);
      fire_col(8'hF0, 8'hFF, 8'h01, 8'h80, -1, -1, "R3 R4 R5 R8 R9");
      load_col(8'h5A, 8'h00, 8'hFF);
      fire_col(8'h8C, 8'h5A, 8'h00, 8'hFF, -1, -1, "R4 R5 R8 R10");
   endtask

   // R2: group 3 is not a target; single-group rewrite leaves others
   task automatic t_write_sel();
      load_col(8'h11, 8'h22, 8'h44);
      wr(2'd3, 8'hEE);
      wr(2'd1, 8'h99);
      fire_col(8'hC0, 8'h11, 8'h99, 8'h44, -1, -1, "R2");
   endtask

   // R7: reading changed mid-column has no effect
   task automatic t_adc_hold();
      load_col(8'h0F, 8'hF0, 8'h3C);
      fire_col(8'h20, 8'h0F, 8'hF0, 8'h3C, 3, -1, "R7");
   endtask

   // R9: start while busy is ignored
   task automatic t_restart();
      load_col(8'h81, 8'h42, 8'h24);
      fire_col(8'hE0, 8'h81, 8'h42, 8'h24, -1, 5, "R9");
      load_col(8'h07, 8'h70, 8'h77);
      fire_col(8'hE0, 8'h07, 8'h70, 8'h77, -1, 3 * (pw_of(8'hE0) + 4) - 1, "R9");
   endtask

   // Count cycles of group-0 drive for one column
   task automatic measure(input logic [7:0] adc, output int w);
      w = 0;
      @(negedge clk);
      adc_val = adc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) begin
         if (|head_drv[7:0]) w++;
         @(negedge clk);
      end
   endtask

   // R6: higher reading, shorter pulse
   task automatic t_mono();
      int wa;
      int wb;
      load_col(8'h01, 8'h00, 8'h00);
      measure(8'h30, wa);
      measure(8'h40, wb);
      chk(wa > wb, "R6", "width order", 32'(wa), 32'(wb + 1));
      chk(wa == pw_of(8'h30), "R6", "width at 0x30", 32'(wa), 32'(pw_of(8'h30)));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_write_sel();
      t_adc_hold();
      t_restart();
      t_mono();
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule